// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional jump is taken. It watches a full-width value on the shared data bus, which is taken to be the contents of the compare register, and a 3-bit condition selector. The selector comes from the three least significant bits of the instruction word. The condition logic is wired permanently to the input of a one-bit result register. That register samples the result only in a step where the load strobe is high, and software cannot read or write it.

In a later step, the jump target is placed on the bus whether or not the jump is taken. The controller raises a program-counter write request in that step. The block passes the request on only when the stored result bit is set. The bus driver and the program counter are outside this block.

The selector codes are:
- 0: never taken.
- 1: always taken.
- 2: taken when the whole value is zero.
- 3: taken when the value is nonzero.
- 4: taken when the top bit is 0.
- 5: taken when the top bit is 1.
- 6 and 7: never taken.

Top module: `branch_cond_eval`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `cond_flag` to 0.
- R2: Selector code 0 loads 0 into `cond_flag` for any bus value.
- R3: Selector code 1 loads 1 into `cond_flag` for any bus value.
- R4: Selector code 2 loads 1 only when every one of the 32 bus bits is 0, and loads 0 otherwise.
- R5: Selector code 3 loads 1 when any bus bit is 1, and loads 0 when the bus is all zeros.
- R6: Selector code 4 loads 1 when bus bit 31 is 0, and loads 0 when it is 1.
- R7: Selector code 5 loads 1 when bus bit 31 is 1, and loads 0 when it is 0.
- R8: Selector codes 6 and 7 load 0 for any bus value.
- R9: The flag updates one edge after a cycle with `load_en` high. When `load_en` is low, the flag keeps its value whatever the bus and selector do.
- R10: `pc_write_en` is high in exactly the cycles where `pc_write_req` is high and the stored flag is 1. It follows the request in the same cycle.
- R11: When `rst` and `load_en` are both high at the same edge, reset wins and the flag becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_value | input | 32 | Value on the shared bus: the compare register contents |
| cond_sel | input | 3 | Condition selector, taken from the three low instruction bits |
| load_en | input | 1 | Strobe that captures the evaluated condition at the next edge |
| pc_write_req | input | 1 | Controller request to load the program counter |
| cond_flag | output | 1 | Stored condition result |
| pc_write_en | output | 1 | Program-counter load, qualified by the stored result |

## Verification
The assertions assume three things about the inputs:
- `rst` is synchronous and held for at least one edge.
- The bus value, selector and strobes are stable and known around each rising edge.
- Every selector value, including the two unused codes, is legal.

The bench respects these rules. It changes inputs only on falling edges and drives only defined values. It walks a table that covers every code with values chosen to expose the zero and sign boundaries: a single set bit at bit 0, bit 16 and bit 31, plus all-ones. Directed steps cover hold without a strobe and reset against a simultaneous load.

// File: rtl/bce_pkg.sv
package bce_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_NEVER   = 3'd0,
    SEL_ALWAYS  = 3'd1,
    SEL_ZERO    = 3'd2,
    SEL_NONZERO = 3'd3,
    SEL_NONNEG  = 3'd4,
    SEL_NEG     = 3'd5
  } cond_sel_e;

endpackage

// File: rtl/bce_zero_detect.sv
module bce_zero_detect #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GROUP_W = 8
) (
  input  logic [DATA_W-1:0] value,
  output logic              is_zero
);

  localparam int unsigned N_GROUPS = (DATA_W + GROUP_W - 1) / GROUP_W;
  localparam int unsigned PAD_W    = N_GROUPS * GROUP_W;

  logic [PAD_W-1:0]    padded;
  logic [N_GROUPS-1:0] group_clear;

  assign padded = PAD_W'(value);

  // Each group is a local NOR, and the group results are combined by an AND.
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_group
    assign group_clear[g] = ~|padded[g*GROUP_W +: GROUP_W];
  end

  assign is_zero = &group_clear;

endmodule

// File: rtl/bce_cond_decode.sv
module bce_cond_decode
  import bce_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             is_zero,
  input  logic             sign_bit,
  output logic             holds
);

  always_comb begin
    case (cond_sel_e'(sel))
      SEL_NEVER:   holds = 1'b0;
      SEL_ALWAYS:  holds = 1'b1;
      SEL_ZERO:    holds = is_zero;
      SEL_NONZERO: holds = ~is_zero;
      SEL_NONNEG:  holds = ~sign_bit;
      SEL_NEG:     holds = sign_bit;
      default:     holds = 1'b0;
    endcase
  end

endmodule

// File: rtl/bce_flag_reg.sv
module bce_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GROUP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_value,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic              load_en,
  input  logic              pc_write_req,
  output logic              cond_flag,
  output logic              pc_write_en
);

  localparam int unsigned SIGN_POS = DATA_W - 1;

  logic value_is_zero;
  logic cond_holds;

  bce_zero_detect #(
    .DATA_W  (DATA_W),
    .GROUP_W (GROUP_W)
  ) u_zero (
    .value   (bus_value),
    .is_zero (value_is_zero)
  );

  bce_cond_decode u_decode (
    .sel      (cond_sel),
    .is_zero  (value_is_zero),
    .sign_bit (bus_value[SIGN_POS]),
    .holds    (cond_holds)
  );

  bce_flag_reg u_flag (
    .clk  (clk),
    .rst  (rst),
    .load (load_en),
    .d    (cond_holds),
    .q    (cond_flag)
  );

  assign pc_write_en = pc_write_req & cond_flag;

endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] bus_value,
  input logic [2:0]        cond_sel,
  input logic              load_en,
  input logic              pc_write_req,
  input logic              cond_flag,
  input logic              pc_write_en
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !cond_flag);

  assert_reset_beats_load_R11: assert property (@(posedge clk)
    (rst && load_en) |=> !cond_flag);

  assert_never_R2: assert property (@(posedge clk) disable iff (rst)
    (load_en && cond_sel == 3'd0) |=> !cond_flag);

  assert_always_R3: assert property (@(posedge clk) disable iff (rst)
    (load_en && cond_sel == 3'd1) |=> cond_flag);

  assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (load_en && cond_sel == 3'd2) |=> (cond_flag == ($past(bus_value) == '0)));

  assert_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    (load_en && cond_sel == 3'd3) |=> (cond_flag == ($past(bus_value) != '0)));

  assert_nonneg_R6: assert property (@(posedge clk) disable iff (rst)
    (load_en && cond_sel == 3'd4) |=> (cond_flag == !$past(bus_value[DATA_W-1])));

  assert_neg_R7: assert property (@(posedge clk) disable iff (rst)
    (load_en && cond_sel == 3'd5) |=> (cond_flag == $past(bus_value[DATA_W-1])));

  assert_unused_false_R8: assert property (@(posedge clk) disable iff (rst)
    (load_en && cond_sel[2:1] == 2'b11) |=> !cond_flag);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(cond_flag));

  assert_gate_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
    pc_write_en |-> (cond_flag && pc_write_req));

  assert_gate_passes_R10: assert property (@(posedge clk) disable iff (rst)
    (cond_flag && pc_write_req) |-> pc_write_en);

endmodule

bind branch_cond_eval bce_checker #(.DATA_W(DATA_W)) u_bce_checker (
  .clk          (clk),
  .rst          (rst),
  .bus_value    (bus_value),
  .cond_sel     (cond_sel),
  .load_en      (load_en),
  .pc_write_req (pc_write_req),
  .cond_flag    (cond_flag),
  .pc_write_en  (pc_write_en)
);

// File: tb/test_branch_cond_eval.sv
`timescale 1ns/1ps
module test_branch_cond_eval;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] bus_value;
  logic [2:0]  cond_sel;
  logic        load_en;
  logic        pc_write_req;
  logic        cond_flag;
  logic        pc_write_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  branch_cond_eval i_branch_cond_eval (
    .clk          (clk),
    .rst          (rst),
    .bus_value    (bus_value),
    .cond_sel     (cond_sel),
    .load_en      (load_en),
    .pc_write_req (pc_write_req),
    .cond_flag    (cond_flag),
    .pc_write_en  (pc_write_en)
  );

  // Each entry is {selector[2:0], bus[31:0], expected flag}.
  localparam int N_VEC = 16;
  localparam logic [35:0] VECS [N_VEC] = '{
    {3'd0, 32'hFFFF_FFFF, 1'b0},
    {3'd1, 32'h0000_0000, 1'b1},
    {3'd2, 32'h0000_0000, 1'b1},
    {3'd2, 32'h0000_0001, 1'b0},
    {3'd2, 32'h8000_0000, 1'b0},
    {3'd2, 32'h0001_0000, 1'b0},
    {3'd3, 32'h0000_0000, 1'b0},
    {3'd3, 32'h0000_0100, 1'b1},
    {3'd4, 32'h7FFF_FFFF, 1'b1},
    {3'd4, 32'h8000_0000, 1'b0},
    {3'd4, 32'h0000_0000, 1'b1},
    {3'd5, 32'h8000_0000, 1'b1},
    {3'd5, 32'h7FFF_FFFF, 1'b0},
    {3'd6, 32'hFFFF_FFFF, 1'b0},
    {3'd7, 32'h0000_0000, 1'b0},
    {3'd1, 32'hDEAD_BEEF, 1'b1}
  };

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs are applied on a falling edge; after the next rising edge,
  // the flag is sampled on the following falling edge.
  task automatic load_and_step(input logic [2:0] s, input logic [31:0] v);
    cond_sel  = s;
    bus_value = v;
    load_en   = 1'b1;
    @(negedge clk);
    load_en   = 1'b0;
  endtask

  initial begin : watchdog
    #50000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_value = '0; cond_sel = '0; load_en = 1'b0; pc_write_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", cond_flag, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      load_and_step(VECS[i][35:33], VECS[i][32:1]);
      check(req_of(VECS[i][35:33]), cond_flag, VECS[i][0]);
    end

    // R9: the flag is set, then the bus and selector are moved with no strobe.
    load_and_step(3'd1, 32'h0);
    cond_sel = 3'd0; bus_value = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    check("R9", cond_flag, 1'b1);
    cond_sel = 3'd2; bus_value = 32'h1;
    @(negedge clk);
    check("R9", cond_flag, 1'b1);

    // R10: the request is gated by the stored flag, in the same cycle.
    pc_write_req = 1'b1;
    #1;
    check("R10", pc_write_en, 1'b1);
    pc_write_req = 1'b0;
    #1;
    check("R10", pc_write_en, 1'b0);
    @(negedge clk);
    load_and_step(3'd0, 32'h0);
    pc_write_req = 1'b1;
    #1;
    check("R10", pc_write_en, 1'b0);
    pc_write_req = 1'b0;

    // R11: reset wins over a simultaneous load of a true condition.
    load_and_step(3'd1, 32'h0);
    check("R3", cond_flag, 1'b1);
    rst = 1'b1; load_en = 1'b1; cond_sel = 3'd1;
    @(negedge clk);
    check("R11", cond_flag, 1'b0);
    rst = 1'b0; load_en = 1'b0;
    @(negedge clk);

    // R1: a plain reset clears a set flag.
    load_and_step(3'd5, 32'h8000_0001);
    check("R7", cond_flag, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", cond_flag, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule